// File: doc/BRIEF.md
# Dual-Window Activity Watchdog

This block watches a processor's activity on a single, already synchronised service line. Each change of level on the line, rising or falling, counts as a service and restarts the timer. After every reset event the watchdog runs a long startup window so the system has time to boot. The first service it sees moves it to a short normal window. If the line holds one level for a whole window, the block raises a one-cycle expiry request for the reset generator.

Windows are counted in millisecond ticks, which come from the same tick source the reset generator uses. Both window lengths are parameters, so simulation can use shortened windows. The block also takes two other inputs. While the system reset status is active, the timer is held clear and the mode returns to startup. While an indication says the service line is floating, the watchdog is disabled and never expires.

Top module: `wdog_dual_window`

## Requirements
- R1: With no service, the watchdog raises an expiry after LONG_TICKS ticks of startup mode following a reset event. Clock cycles with no tick do not advance the timer.
- R2: A rising level change on the service line clears the timer and switches the watchdog from startup to normal mode.
- R3: A falling level change on the service line also counts as a service, with the same effect as a rising one.
- R4: In normal mode, the expiry comes on the SHORT_TICKS-th tick after the last service.
- R5: The expiry output is high for exactly one clock cycle, the cycle after the tick that completes the window.
- R6: After an expiry, ticks and service edges cause no further expiry until the system reset status has been asserted and then released.
- R7: While the system reset status is active, the timer is held clear and the mode is forced to startup. A reset that arrives in normal mode therefore restores the long window.
- R8: While the floating indication is high, the timer is held clear and the expiry output stays low, whatever the ticks and line levels are.
- R9: A line change in the same cycle as the floating indication falls is not counted as a service: the watchdog stays in its current mode and keeps counting from zero.
- R10: A service in the same cycle as the tick that would complete the window has priority. No expiry is raised and the timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_ms_i | input | 1 | One-cycle millisecond tick shared with the reset generator |
| wdi_sync_i | input | 1 | Synchronised watchdog service line |
| wdi_float_i | input | 1 | High when the service line is detected as unconnected; disables the watchdog |
| sys_rst_act_i | input | 1 | High while the system reset output is asserted |
| wd_expire_o | output | 1 | One-cycle expiry request to the reset generator |

## Verification
Directed runs let the line sit idle in each mode. An expiry exactly at the long or the short tick count tells the two windows apart and shows which mode the block is in. Rising and falling services are each followed by a short-window expiry, which shows that both directions switch the mode. Corner runs place a service on the completing tick, release the floating indication in the same cycle as a line change, and apply reset during normal mode; each of these is told apart by whether the later expiry lands at the short count, at the long count, or not at all. A long stretch of random ticks, toggles, floating bursts and reset pulses is then compared cycle by cycle against a behavioural model of the requirements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // operating mode of the watchdog
   typedef enum logic [1:0] {
      WD_START  = 2'd0,   // long window after a reset event
      WD_NORMAL = 2'd1,   // short window after the first service
      WD_HALT   = 2'd2    // expired, waiting for a reset cycle
   } wd_mode_e;
endpackage

// File: rtl/wdog_edge_sense.sv
module wdog_edge_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic off_i,
   output logic edge_o
);
   logic prev_q;
   logic off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         off_q  <= 1'b1;
      end else begin
         prev_q <= line_i;
         off_q  <= off_i;
      end
   end

   // a change counts only when enabled now and in the previous cycle
   assign edge_o = (line_i ^ prev_q) & ~off_i & ~off_q;

   // R9
   leave_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_i |=> !edge_o || !$past(off_i) && 1'b0 || !$fell(off_i) || !edge_o);
endmodule

// File: rtl/wdog_win_count.sv
module wdog_win_count #(
   parameter int LONG_TICKS  = 52500,
   parameter int SHORT_TICKS = 1680,
   parameter int CNT_W       = $clog2(LONG_TICKS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   input  logic short_sel_i,
   output logic done_o
);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;

   assign last_val = short_sel_i ? SHORT_LAST : LONG_LAST;
   assign done_o   = tick_i & ~clr_i & (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || done_o) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LONG_LAST);
   // R2
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_q == '0);
   // R4
   short_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (short_sel_i && !clr_i && $past(short_sel_i) && !$past(clr_i)) |-> cnt_q <= SHORT_LAST);
endmodule

// File: rtl/wdog_mode_fsm.sv
module wdog_mode_fsm
   import wdog_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sys_rst_i,
   input  logic     float_i,
   input  logic     edge_i,
   input  logic     done_i,
   output wd_mode_e mode_o,
   output logic     hold_o,
   output logic     expire_o
);
   wd_mode_e mode_q, mode_d;
   logic     expire_q;

   // counter is held clear in reset, while disabled, after expiry and on service
   assign hold_o = sys_rst_i | float_i | (mode_q == WD_HALT) | edge_i;

   always_comb begin
      mode_d = mode_q;
      if (sys_rst_i) begin
         mode_d = WD_START;
      end else if (float_i || mode_q == WD_HALT) begin
         mode_d = mode_q;
      end else if (edge_i) begin
         mode_d = WD_NORMAL;
      end else if (done_i) begin
         mode_d = WD_HALT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= WD_START;
         expire_q <= 1'b0;
      end else begin
         mode_q   <= mode_d;
         expire_q <= done_i;
      end
   end

   assign mode_o   = mode_q;
   assign expire_o = expire_q;

   // R5
   expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o);
   // R6
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == WD_HALT) |=> !expire_o);
   // R7
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_i |=> (mode_q == WD_START) && !expire_o);
   // R8
   float_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      float_i |=> !expire_o);
   // R2
   edge_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && !sys_rst_i && mode_q != WD_HALT) |=> mode_q == WD_NORMAL);
   // R6
   expire_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> mode_q == WD_HALT);
endmodule

// File: rtl/wdog_dual_window.sv
module wdog_dual_window
   import wdog_pkg::*;
#(
   parameter int LONG_TICKS  = 52500,
   parameter int SHORT_TICKS = 1680
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_ms_i,
   input  logic wdi_sync_i,
   input  logic wdi_float_i,
   input  logic sys_rst_act_i,
   output logic wd_expire_o
);
   localparam int CNT_W = (LONG_TICKS > 2) ? $clog2(LONG_TICKS) : 1;

   generate
      if (SHORT_TICKS < 2) begin : g_short_bad
         $error("SHORT_TICKS must be at least 2");
      end
      if (LONG_TICKS <= SHORT_TICKS) begin : g_long_bad
         $error("LONG_TICKS must exceed SHORT_TICKS");
      end
   endgenerate

   logic     edge_w;
   logic     hold_w;
   logic     done_w;
   wd_mode_e mode_w;

   wdog_edge_sense u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (wdi_sync_i),
      .off_i  (wdi_float_i),
      .edge_o (edge_w)
   );

   wdog_win_count #(
      .LONG_TICKS  (LONG_TICKS),
      .SHORT_TICKS (SHORT_TICKS),
      .CNT_W       (CNT_W)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (hold_w),
      .tick_i      (tick_ms_i),
      .short_sel_i (mode_w == WD_NORMAL),
      .done_o      (done_w)
   );

   wdog_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sys_rst_i (sys_rst_act_i),
      .float_i   (wdi_float_i),
      .edge_i    (edge_w),
      .done_i    (done_w),
      .mode_o    (mode_w),
      .hold_o    (hold_w),
      .expire_o  (wd_expire_o)
   );
endmodule

// File: tb/wdog_dual_window_tb.sv
module wdog_dual_window_tb_top;
   localparam int LONG  = 40;
   localparam int SHORT = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic line = 1'b0;
   logic flt = 1'b0;
   logic sysr = 1'b1;
   logic expire;

   int n_chk = 0;
   int n_bad = 0;
   int exp_seen = 0;
   int cyc_n = 0;

   always #2.5 clk = ~clk;

   wdog_dual_window #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_ms_i     (tick),
      .wdi_sync_i    (line),
      .wdi_float_i   (flt),
      .sys_rst_act_i (sysr),
      .wd_expire_o   (expire)
   );

   // behavioural model built from the requirements
   int m_cnt = 0;
   bit m_norm = 0, m_halt = 0, m_e = 0, m_prev = 0, m_offq = 1;

   function automatic int win_len(bit norm);
      return norm ? SHORT : LONG;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_norm = 0; m_halt = 0; m_e = 0; m_prev = 0; m_offq = 1;
      end else begin
         m_e = 0;
         if (sysr) begin
            m_cnt = 0; m_norm = 0; m_halt = 0;
         end else if (flt || m_halt) begin
            m_cnt = 0;
         end else if ((line != m_prev) && !m_offq) begin
            m_cnt = 0; m_norm = 1;
         end else if (tick) begin
            if (m_cnt == win_len(m_norm) - 1) begin
               m_e = 1; m_halt = 1; m_cnt = 0;
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
         m_prev = line;
         m_offq = flt;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   always @(negedge clk) begin
      cyc_n++;
      if (rst_n) begin
         if (expire) exp_seen++;
         chk(expire === m_e, "R5 model compare", int'(expire), int'(m_e));
      end
      if (cyc_n > 100000) begin
         n_bad++;
         $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc_n, 100000);
         $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
         $finish;
      end
   end

   task automatic cyc(input bit tk, input bit tg);
      tick = tk;
      if (tg) line = ~line;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(1'b1, 1'b0);
         cyc(1'b0, 1'b0);
      end
   endtask

   task automatic do_reset(input bit lvl);
      sysr = 1'b1;
      line = lvl;
      cyc(1'b0, 1'b0);
      cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b0);
      sysr = 1'b0;
      cyc(1'b0, 1'b0);
   endtask

   int base;
   bit tk, tg;

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(expire === 1'b0, "R5 reset state", int'(expire), 0);
      cyc(1'b0, 1'b0);
      sysr = 1'b0;
      cyc(1'b0, 1'b0);

      // R1: long window from startup, idle cycles do not count
      base = exp_seen;
      ticks(LONG - 1);
      repeat (10) cyc(1'b0, 1'b0);
      chk(exp_seen == base, "R1 no early expiry", exp_seen - base, 0);
      cyc(1'b1, 1'b0);
      chk(expire === 1'b1, "R1 expiry at long count", int'(expire), 1);
      cyc(1'b0, 1'b0);
      chk(expire === 1'b0, "R5 single cycle pulse", int'(expire), 0);

      // R6: halted until reset cycle
      base = exp_seen;
      for (int i = 0; i < LONG + 5; i++) cyc(1'b1, 1'b1);
      chk(exp_seen == base, "R6 silent after expiry", exp_seen - base, 0);

      // R2 + R4: rising service selects short window
      do_reset(1'b0);
      cyc(1'b0, 1'b1);
      base = exp_seen;
      ticks(SHORT - 1);
      chk(exp_seen == base, "R4 no early expiry", exp_seen - base, 0);
      cyc(1'b1, 1'b0);
      chk(expire === 1'b1, "R2 R4 short expiry after rising", int'(expire), 1);

      // R3: falling service
      do_reset(1'b1);
      cyc(1'b0, 1'b1);
      ticks(SHORT - 1);
      cyc(1'b1, 1'b0);
      chk(expire === 1'b1, "R3 short expiry after falling", int'(expire), 1);

      // R7: reset in normal mode restores long window
      do_reset(1'b0);
      cyc(1'b0, 1'b1);
      ticks(SHORT - 2);
      sysr = 1'b1;
      cyc(1'b1, 1'b0);
      cyc(1'b1, 1'b0);
      sysr = 1'b0;
      cyc(1'b0, 1'b0);
      base = exp_seen;
      ticks(SHORT + 2);
      chk(exp_seen == base, "R7 long window after reset", exp_seen - base, 0);
      ticks(LONG - SHORT - 3);
      cyc(1'b1, 1'b0);
      chk(expire === 1'b1, "R7 expiry at long count", int'(expire), 1);

      // R8: floating line disables
      do_reset(1'b0);
      flt = 1'b1;
      base = exp_seen;
      for (int i = 0; i < 3 * LONG; i++) cyc(1'b1, (i % 7) == 0);
      chk(exp_seen == base, "R8 no expiry while floating", exp_seen - base, 0);

      // R9: change in release cycle is not a service
      flt = 1'b0;
      cyc(1'b0, 1'b1);
      ticks(SHORT);
      chk(exp_seen == base, "R9 stays in startup", exp_seen - base, 0);
      ticks(LONG - SHORT - 1);
      cyc(1'b1, 1'b0);
      chk(expire === 1'b1, "R9 expiry at long count", int'(expire), 1);

      // R10: service beats completing tick
      do_reset(1'b0);
      cyc(1'b0, 1'b1);
      ticks(SHORT - 1);
      cyc(1'b1, 1'b1);
      chk(expire === 1'b0, "R10 service wins over tick", int'(expire), 0);
      base = exp_seen;
      ticks(SHORT - 1);
      chk(exp_seen == base, "R10 timer restarted", exp_seen - base, 0);
      cyc(1'b1, 1'b0);
      chk(expire === 1'b1, "R10 expiry after restart", int'(expire), 1);

      // random phase, checked against the model every cycle
      base = exp_seen;
      for (int i = 0; i < 6000; i++) begin
         tk = ($urandom % 4) == 0;
         tg = ($urandom % 40) == 0;
         if (($urandom % 300) == 0) flt = ~flt;
         sysr = ($urandom % 400) == 0;
         cyc(tk, tg);
      end
      sysr = 1'b0;
      flt = 1'b0;
      chk(exp_seen > base, "R1 random phase saw expiries", exp_seen - base, 1);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule